// File: doc/BRIEF.md
# Latched and Registered Bidirectional Bus Transceiver

This block passes data between two 18-bit buses, called side A and side B. Data is never inverted. Each direction has its own storage element and its own four control inputs. The first is an open-gate control: while it is high the path is transparent. The second is a path clock that stores data on its rising edge. The third is an active-low clock gate that lets edges through. The fourth is an active-low output enable. The block does not model tri-state pins. Instead, each side has a data output plus a drive flag, and surrounding logic uses the flag to control a pad or a bus multiplexer.

Every input is sampled by the core clock `clk`. A path clock is a slow, level-style signal, and the core clock samples it. A rise counts when the path clock is seen low on one core edge and high on the next. In the transparent state the data output follows its input in the same cycle, with no register in between. An active-high synchronous reset stands in for power-up. It clears both stores and keeps both drive flags low.

Top module: `bus_xcvr_latched`

## Requirements
- R1: Each direction carries 18 bits without inversion. The A-to-B path (input `a_in`, output `b_out`) and the B-to-A path (input `b_in`, output `a_out`) behave alike. Each uses only its own controls, and neither disturbs the other.
- R2: While a path's open-gate input is 1, its data output equals its data input in the same cycle. The path clock and the clock gate have no effect then.
- R3: While the open-gate input is 0 and no accepted clock rise occurs, the stored value, and therefore the output, stays unchanged when the input data changes.
- R4: With the open-gate input at 0 and the active-low clock gate at 0, a path clock sampled 0 on one core edge and 1 on the next loads the input present at that second edge. The new value is visible after that edge.
- R5: While the active-low clock gate is 1, rises of the path clock are ignored and the stored value is kept.
- R6: The output enable is active low. When it is 1, the drive flag for that side is 0. When it is 0, the drive flag is 1 and the data output shows the stored or passed-through value.
- R7: While reset is 1, both drive flags are 0. Reset clears both stores to 0. After reset, a path clock must be seen low before a rise can count, so a clock that is already high when reset is released does not load data.
- R8: When the open-gate input falls, the path holds the value that passed through on the last core edge at which the gate was still 1.
- R9: Path clock rises that happen while the gate is open do not alter the value held once the gate closes. The held value is the last input that passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| a_in | input | 18 | Data arriving on side A |
| b_in | input | 18 | Data arriving on side B |
| ab_oe_n | input | 1 | Active-low output enable for side B (A-to-B path) |
| ab_le | input | 1 | Open-gate (transparent) control, A-to-B path |
| ab_cp | input | 1 | Path clock, A-to-B path; stores data on its rising edge |
| ab_ce_n | input | 1 | Active-low clock gate, A-to-B path |
| ba_oe_n | input | 1 | Active-low output enable for side A (B-to-A path) |
| ba_le | input | 1 | Open-gate (transparent) control, B-to-A path |
| ba_cp | input | 1 | Path clock, B-to-A path; stores data on its rising edge |
| ba_ce_n | input | 1 | Active-low clock gate, B-to-A path |
| a_out | output | 18 | Data presented to side A |
| a_drive | output | 1 | Side A is driven when 1 |
| b_out | output | 18 | Data presented to side B |
| b_drive | output | 1 | Side B is driven when 1 |

## Verification
The bench uses alternating patterns (all ones, checkerboards) to expose inverted or swapped bits and crossed paths. Data changes while the gate is open, and the held value is compared with the last value that passed through; this shows whether a flop captures one edge late. Clock rises arrive with the clock gate set, with the open gate active, and just after reset while the clock is already high. Each case shows whether edges are qualified correctly. A randomised run with independent controls on both paths is compared against a reference model after every input change.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_DATA_W = 18;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic cp;
        logic ce_n;
    } dir_ctrl_t;

    function automatic logic load_ok(input logic rise, input logic ce_n);
        return rise & ~ce_n;
    endfunction

    function automatic logic drive_ok(input logic oe_n, input logic rst);
        return ~oe_n & ~rst;
    endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R4

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate_open,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)                   q_r <= '0;
        else if (gate_open | load) q_r <= din;
    end

    assign q = q_r;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && !load) |=> $stable(q)); // R3
    AST_TAKE_INPUT: assert property (@(posedge clk) disable iff (rst)
        (gate_open || load) |=> (q == $past(din))); // R4

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic         cp_rise;
    logic         load;
    logic [W-1:0] held;

    xcvr_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctrl.cp),
        .rise (cp_rise)
    );

    assign load = load_ok(cp_rise, ctrl.ce_n);

    xcvr_store #(.W(W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .gate_open (ctrl.le),
        .load      (load),
        .din       (din),
        .q         (held)
    );

    assign dout  = ctrl.le ? din : held;
    assign drive = drive_ok(ctrl.oe_n, rst);

    AST_GATED_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ce_n && !ctrl.le) |=> $stable(held)); // R5

endmodule

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    input  logic         ba_ce_n,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic [W-1:0] b_out,
    output logic         b_drive
);
    localparam int unsigned NDIR = 2;

    dir_ctrl_t    ctrl_v [NDIR];
    logic [W-1:0] din_v  [NDIR];
    logic [W-1:0] dout_v [NDIR];
    logic         drv_v  [NDIR];

    assign ctrl_v[0] = '{oe_n: ab_oe_n, le: ab_le, cp: ab_cp, ce_n: ab_ce_n};
    assign ctrl_v[1] = '{oe_n: ba_oe_n, le: ba_le, cp: ba_cp, ce_n: ba_ce_n};
    assign din_v[0]  = a_in;
    assign din_v[1]  = b_in;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        xcvr_path #(.W(W)) u_path (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl_v[d]),
            .din   (din_v[d]),
            .dout  (dout_v[d]),
            .drive (drv_v[d])
        );
    end

    assign b_out   = dout_v[0];
    assign b_drive = drv_v[0];
    assign a_out   = dout_v[1];
    assign a_drive = drv_v[1];

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n) |-> (b_drive && b_out == a_in)); // R2
    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> !a_drive); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_le) |-> (b_out == '0)); // R7

    always_comb begin
        if (rst) AST_RESET_NO_DRIVE: assert (!a_drive && !b_drive); // R7
    end

endmodule

// File: tb/bus_xcvr_latched_test.sv
module bus_xcvr_latched_test;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_xcvr_latched uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
    );

    // reference model: open gate first, then qualified clock rise, then hold
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_ab_prev = 1'b1, m_ba_prev = 1'b1;
    always @(posedge clk) begin
        if (rst) begin
            m_ab <= '0; m_ba <= '0; m_ab_prev <= 1'b1; m_ba_prev <= 1'b1;
        end else begin
            if (ab_le || (ab_cp && !m_ab_prev && !ab_ce_n)) m_ab <= a_in;
            if (ba_le || (ba_cp && !m_ba_prev && !ba_ce_n)) m_ba <= b_in;
            m_ab_prev <= ab_cp; m_ba_prev <= ba_cp;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk_val(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_model(string req);
        logic [W-1:0] eb, ea;
        eb = ab_le ? a_in : m_ab;
        ea = ba_le ? b_in : m_ba;
        chk_bit(req, b_drive, !ab_oe_n && !rst);
        chk_bit(req, a_drive, !ba_oe_n && !rst);
        if (b_drive) chk_val(req, b_out, eb);
        if (a_drive) chk_val(req, a_out, ea);
    endtask

    task automatic t_reset();
        ab_oe_n = 1'b0; ba_oe_n = 1'b0; ab_cp = 1'b1; ba_cp = 1'b1;
        a_in = 18'h3FFFF; b_in = 18'h15555;
        #1;
        chk_bit("R7 drive off in reset", b_drive, 1'b0);
        chk_bit("R7 drive off in reset", a_drive, 1'b0);
        tick(); rst = 1'b0;
        tick();  // clock already high at release: no load
        tick();
        chk_bit("R6 drive on", b_drive, 1'b1);
        chk_val("R7 store cleared", b_out, '0);
        chk_val("R7 store cleared", a_out, '0);
        ab_cp = 1'b0; ba_cp = 1'b0; tick();
    endtask

    task automatic t_transparent();
        ab_le = 1'b1; ab_ce_n = 1'b1; a_in = 18'h2AAAA; #1;
        chk_val("R2 same-cycle pass", b_out, 18'h2AAAA);
        chk_val("R1 other path untouched", a_out, '0);
        ab_cp = 1'b1; a_in = 18'h15555; #1;
        chk_val("R2 clock ignored", b_out, 18'h15555);
        tick(); ab_cp = 1'b0; tick();
        ab_le = 1'b0; a_in = 18'h00F0F; tick();
        chk_val("R8 held last passed value", b_out, 18'h15555);
        chk_val("R9 open-gate rise no effect", b_out, 18'h15555);
        a_in = 18'h3F0F0; tick(); tick();
        chk_val("R3 hold with data change", b_out, 18'h15555);
    endtask

    task automatic t_clocked();
        ab_ce_n = 1'b0; a_in = 18'h12345; tick();
        ab_cp = 1'b1; tick();
        a_in = 18'h0BEEF; tick();
        chk_val("R4 rise loads", b_out, 18'h12345);
        ab_cp = 1'b0; tick();
        ab_ce_n = 1'b1; tick(); ab_cp = 1'b1; tick(); ab_cp = 1'b0; tick();
        chk_val("R5 gated rise ignored", b_out, 18'h12345);
        ab_oe_n = 1'b1; #1;
        chk_bit("R6 drive off", b_drive, 1'b0);
        ab_oe_n = 1'b0; #1;
        chk_bit("R6 drive back on", b_drive, 1'b1);
    endtask

    task automatic t_reverse();
        ba_le = 1'b1; b_in = 18'h3C3C3; tick();
        ba_le = 1'b0; b_in = 18'h00001; tick();
        chk_val("R1 reverse path hold", a_out, 18'h3C3C3);
        chk_val("R1 forward untouched", b_out, 18'h12345);
        ba_ce_n = 1'b0; ba_cp = 1'b1; tick();
        ba_cp = 1'b0; b_in = 18'h2FFFF; tick();
        chk_val("R4 reverse rise loads", a_out, 18'h00001);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            {ab_oe_n, ab_le, ab_cp, ab_ce_n} = 4'($urandom);
            {ba_oe_n, ba_le, ba_cp, ba_ce_n} = 4'($urandom);
            #1; chk_model("R1 model compare");
            tick(); chk_model("R1 model compare");
        end
    endtask

    initial begin
        #2;
        t_reset();
        t_transparent();
        t_clocked();
        t_reverse();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule